// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block keeps the operating state of a serial peripheral core. Software moves the core between three states: reset, run and pause. It does this by writing a two-bit command code to the state field, one write at a time. The block does not apply a change at once. It drops a valid flag, waits a parameterised number of clocks (`SETTLE`) that stands for the time the hardware needs to settle, and then shows the new state with the valid flag high again. Software polls the status word until the flag returns before it issues the next command.

Pause is the state in which the transmit FIFO is preloaded, so leaving pause for reset is guarded. A direct reset code is not honoured in pause. The core leaves pause for reset only after the clear code is written on two writes in a row. A software reset strobe drops the core into reset from any state at any time. The block decodes the visible state onto three one-hot controls for the data path. While the reset control is high, the data path holds its enables low and clears its transfer counters.

Top module: `run_state_ctrl`

## Requirements
- R1: The status word carries the state in bits [1:0] (reset = 0, run = 1, pause = 3; code 2 never appears), the valid flag in bit 2 and the sticky error flag in bit 3. After reset the word reads 4'b0100.
- R2: A state write that is accepted while valid is high drops valid from the next cycle. Valid stays low for exactly `SETTLE` cycles, and the old state stays visible during that time. The new state appears in the same cycle in which valid rises. Codes 1 and 3 are always accepted, and code 0 is accepted in every state except pause.
- R3: A state write made while valid is low is ignored. The state it asked for never appears, and error bit 3 is set. The error bit stays set across later accepted writes.
- R4: In pause, a first clear write (code 2) leaves the state at pause and valid high. A second clear write on the next write starts the settle to reset.
- R5: Any write other than a clear, made after a lone clear, cancels the pending clear. A following single clear write then leaves the core in pause.
- R6: Code 0 written in pause, and code 2 written outside pause, change neither the state nor the valid flag, and they do not set the error bit.
- R7: A software reset strobe forces the state to reset on the next cycle. It clears the error bit and any pending clear, and it holds valid low for `SETTLE` cycles. The strobe takes priority over a state write in the same cycle, and that write neither takes effect nor sets the error bit.
- R8: `core_run`, `core_pause` and `core_reset` are a one-hot decode of the visible state (run, pause, reset).
- R9: A full transfer sequence completes in order: reset, then run, then pause, then run, then pause, then a pair of clears back to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | One-cycle strobe: write `cmd_code` to the state field |
| cmd_code | input | 2 | Requested state code (0 reset, 1 run, 2 clear, 3 pause) |
| swrst_wr | input | 1 | One-cycle software reset strobe |
| status | output | 4 | {error, valid, state[1:0]} |
| core_run | output | 1 | Data path runs |
| core_pause | output | 1 | Data path paused (FIFO preload) |
| core_reset | output | 1 | Data path held idle, transfer counters cleared |

## Verification
The block registers each strobe on the clock edge that samples it. The bench drives every strobe for one cycle from a falling edge. It then samples the status word at the next falling edge. At that point valid must already be low after an accepted write or a software reset, and the word must be unchanged after an ignored write. The bench counts how many falling-edge samples show valid low until it rises, and requires exactly `SETTLE`. It compares the state and the decoded controls in the first sample where valid is high. For ignored writes it checks the status word at the first falling edge and again one cycle later, so a late, delayed change is still caught.

// File: rtl/run_state_ctrl.sv
module run_state_ctrl #(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_code,
  input  logic       swrst_wr,
  output logic [3:0] status,
  output logic       core_run,
  output logic       core_pause,
  output logic       core_reset
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE);
  localparam logic [1:0] ST_RST = 2'd0, ST_RUN = 2'd1, ST_CLR = 2'd2, ST_PAU = 2'd3;

  logic [1:0]    cur, tgt;
  logic          valid, err, pend;
  logic [CW-1:0] cnt;

  wire accept   = cmd_wr & valid & ~swrst_wr;
  wire busy_wr  = cmd_wr & ~valid & ~swrst_wr;
  wire is_clr   = cmd_code == ST_CLR;
  wire in_pause = cur == ST_PAU;
  wire go_clr   = accept & is_clr & in_pause & pend;
  wire go_norm  = accept & ~is_clr & ~(in_pause & (cmd_code == ST_RST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= ST_RST;
      tgt   <= ST_RST;
      valid <= 1'b1;
      err   <= 1'b0;
      pend  <= 1'b0;
      cnt   <= '0;
    end else if (swrst_wr) begin
      cur   <= ST_RST;
      tgt   <= ST_RST;
      valid <= 1'b0;
      err   <= 1'b0;
      pend  <= 1'b0;
      cnt   <= SETTLE_LD;
    end else if (go_clr || go_norm) begin
      tgt   <= go_clr ? ST_RST : cmd_code;
      valid <= 1'b0;
      pend  <= 1'b0;
      cnt   <= SETTLE_LD;
    end else if (!valid) begin
      if (busy_wr) err <= 1'b1;
      if (cnt <= 1) begin
        valid <= 1'b1;
        cur   <= tgt;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (accept) begin
      pend <= is_clr & in_pause & ~pend;
    end
  end

  assign status     = {err, valid, cur};
  assign core_run   = cur == ST_RUN;
  assign core_pause = cur == ST_PAU;
  assign core_reset = cur == ST_RST;
endmodule

// File: rtl/run_state_ctrl_chk.sv
module run_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [1:0] cmd_code,
  input logic       swrst_wr,
  input logic [3:0] status,
  input logic       core_run,
  input logic       core_pause,
  input logic       core_reset
);
  AST_STATE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status[1:0] != 2'd2); // R1

  AST_ACCEPT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status[2] && !swrst_wr && (cmd_code == 2'd1 || cmd_code == 2'd3)) |=> !status[2]); // R2

  AST_STATE_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && !$past(swrst_wr)) |-> $stable(status[1:0])); // R2

  AST_BUSY_WRITE_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !status[2] && !swrst_wr) |=> status[3]); // R3

  AST_NO_DIRECT_PAUSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status[2] && !swrst_wr && status[1:0] == 2'd3 && cmd_code == 2'd0)
      |=> (status[1:0] == 2'd3 && status[2])); // R6

  AST_SWRST_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_wr |=> (status[1:0] == 2'd0 && !status[3] && !status[2])); // R7

  AST_CONTROL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({core_run, core_pause, core_reset})); // R8
endmodule

bind run_state_ctrl run_state_ctrl_chk u_chk (.*);

// File: tb/run_state_ctrl_test.sv
`timescale 1ns/1ps
module run_state_ctrl_test;
  localparam int SETTLE = 4;

  logic       clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0, swrst_wr = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic [3:0] status;
  logic       core_run, core_pause, core_reset;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  run_state_ctrl #(.SETTLE(SETTLE)) uut (.*);

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ctl_of(input logic [1:0] s);
    return (s == 2'd1) ? 4 : (s == 2'd3) ? 2 : 1;
  endfunction

  task automatic chk_state(input string req, input logic [1:0] s);
    chk_eq(req, int'(status[2:0]), int'({1'b1, s}));
    chk_eq({req, " ctl R8"}, int'({core_run, core_pause, core_reset}), ctl_of(s));
  endtask

  task automatic wr(input logic [1:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic sr();
    @(negedge clk); swrst_wr = 1'b1;
    @(negedge clk); swrst_wr = 1'b0;
  endtask

  task automatic settle(output int n);
    n = 0;
    while (!status[2] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic goto_state(input logic [1:0] s);
    int n;
    sr(); settle(n);
    if (s != 2'd0) begin wr(2'd1); settle(n); end
    if (s == 2'd3) begin wr(2'd3); settle(n); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 reset status", int'(status), 4);
    chk_eq("R8 reset controls", int'({core_run, core_pause, core_reset}), 1);

    // R2 R6 R8: every start state against every code
    for (int si = 0; si < 3; si++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] s;
        bit acc;
        s = (si == 2) ? 2'd3 : 2'(si);
        goto_state(s);
        chk_state("R1 start", s);
        wr(2'(c));
        acc = (c != 2) && !(s == 2'd3 && c == 0);
        if (acc) begin
          chk_eq("R2 valid drops", int'(status[2]), 0);
          chk_eq("R2 old state held", int'(status[1:0]), int'(s));
          settle(n);
          chk_eq("R2 settle cycles", n, SETTLE);
          chk_state("R2 new state", 2'(c));
          chk_eq("R2 no error", int'(status[3]), 0);
        end else begin
          chk_eq("R6 ignored now", int'(status), int'({2'b01, s}));
          @(negedge clk);
          chk_eq("R6 ignored later", int'(status), int'({2'b01, s}));
        end
      end
    end

    // R4: clear pair from pause
    goto_state(2'd3);
    wr(2'd2);
    chk_state("R4 lone clear keeps pause", 2'd3);
    wr(2'd2);
    chk_eq("R4 second clear drops valid", int'(status[2]), 0);
    settle(n);
    chk_eq("R4 settle cycles", n, SETTLE);
    chk_state("R4 reached reset", 2'd0);

    // R5: cancel by ignored code 0
    goto_state(2'd3);
    wr(2'd2); wr(2'd0); wr(2'd2);
    chk_state("R5 cancel by code 0", 2'd3);
    wr(2'd2);
    settle(n);
    chk_state("R5 then pair completes", 2'd0);

    // R5: cancel by accepted pause write
    goto_state(2'd3);
    wr(2'd2); wr(2'd3); settle(n);
    wr(2'd2);
    chk_state("R5 cancel by pause write", 2'd3);

    // R3: write while busy
    goto_state(2'd0);
    wr(2'd1);
    wr(2'd3);
    settle(n);
    chk_eq("R3 busy write ignored", int'(status[1:0]), 1);
    chk_eq("R3 error set", int'(status[3]), 1);
    wr(2'd3); settle(n);
    chk_eq("R3 error sticky", int'(status), 4'b1111);

    // R7: software reset clears error
    sr();
    chk_eq("R7 swrst status", int'(status), 0);
    settle(n);
    chk_eq("R7 settle cycles", n, SETTLE);
    chk_state("R7 in reset", 2'd0);
    chk_eq("R7 error cleared", int'(status[3]), 0);

    // R7: software reset during a settle
    wr(2'd1);
    sr();
    chk_eq("R7 abort status", int'(status), 0);
    settle(n);
    chk_eq("R7 abort settle", n, SETTLE);
    chk_state("R7 abort final", 2'd0);

    // R7: priority over simultaneous write
    @(negedge clk); swrst_wr = 1'b1; cmd_wr = 1'b1; cmd_code = 2'd1;
    @(negedge clk); swrst_wr = 1'b0; cmd_wr = 1'b0;
    settle(n);
    chk_eq("R7 priority status", int'(status), 4);

    // R9: full transfer sequence
    goto_state(2'd0);
    wr(2'd1); settle(n); chk_state("R9 run", 2'd1);
    wr(2'd3); settle(n); chk_state("R9 pause preload", 2'd3);
    wr(2'd1); settle(n); chk_state("R9 run again", 2'd1);
    wr(2'd3); settle(n); chk_state("R9 pause end", 2'd3);
    wr(2'd2); wr(2'd2); settle(n); chk_state("R9 back to reset", 2'd0);
    chk_eq("R9 no error", int'(status[3]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule